// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the controller side of a host-shared transmit queue. The host keeps a ring of 16-byte descriptors in memory. It fills in a descriptor's buffer address, its negated byte count and its misc word. Then it writes the status halfword, and setting the ownership bit in that write hands the entry to the engine. The engine inspects the descriptor at its current index when the host strobes a poll demand, or when its own poll timer expires. If the engine owns the entry, it reads the buffer pointer and streams the frame byte by byte to a simple valid/ready MAC transmit port. It then writes back the misc word and, last of all, the status halfword with ownership returned to the host.

After each write-back the index advances modulo the ring size, and the engine goes straight on to the next entry. It stops only when it finds an entry the host still holds, and it waits at that index for the next poll. All descriptor and buffer traffic goes through one 32-bit memory port with a request/acknowledge handshake and byte enables. The ring base is a byte address, and the ring size comes from a 4-bit log2 field in a 16-bit ring-length word.

Top module: `txr_ring_engine`

## Requirements
- R1: While reset is held, `mem_req` and `mac_valid` are low. After reset the first descriptor inspected is the one at `ring_base`.
- R2: The engine first reads the word at descriptor offset 4, where bits 31:16 hold the status and bits 15:0 hold the encoded length. If status bit 15 (ownership) is clear, it sends no byte, writes nothing, and stays at the same index.
- R3: Some entries are owned, have status bit 9 (start of frame) and bit 8 (end of frame) set, and have a count from 1 to MAX_BYTES. The count is `(-length) & 0xFFF`. For such an entry the engine sends exactly that many bytes, starting at the byte address read from descriptor offset 0, in ascending address order. Byte lane k of each 32-bit word carries address bits [1:0] = k. `mac_last` is high only on the final byte.
- R4: After a frame the engine writes the misc word (offset 8) as zero. It then writes the status halfword with byte enables 4'b1100, with bit 15 cleared and every other status bit kept.
- R5: Some owned entries have a count of zero, a count above MAX_BYTES, or status bit 9 or bit 8 clear. For such an entry no byte is sent, misc is written as 32'h4000_0000, and status gets bit 14 set and bit 15 cleared.
- R6: Descriptor address = `ring_base` + 16 × index. The index wraps modulo 2^`ring_len[15:12]` (clamped to MAX_LOG2), so a field of 0 keeps the engine on entry 0.
- R7: After a write-back the engine inspects the next entry without any new poll, so consecutive owned entries go out on one demand.
- R8: A `poll_demand` pulse while idle starts a read of the current status word on the next cycle. A demand that arrives while busy is held and acted on once idle.
- R9: With POLL_CYCLES nonzero, an owned entry is picked up within POLL_CYCLES cycles even without a poll demand.
- R10: A memory request keeps its address, direction and data until `mem_ack`. A MAC byte keeps `mac_data` and `mac_last` until `mac_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_demand | input | 1 | One-cycle strobe: inspect the current descriptor now |
| ring_base | input | AW | Byte address of descriptor 0, 16-byte aligned |
| ring_len | input | 16 | Ring-length word, bits 15:12 = log2 of entry count |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| mac_valid | output | 1 | Frame byte available |
| mac_data | output | 8 | Frame byte |
| mac_last | output | 1 | Final byte of the frame |
| mac_ready | input | 1 | MAC accepts the byte |

## Verification
A corrupted ring index shows up as a status write-back at the wrong descriptor offset within one frame time, so host memory gives it away at once. A lost ownership decision shows up either as bytes on the MAC port for an entry the host still holds, or as an entry whose bit 15 never clears. A byte pointer that goes wrong in the buffer feeder corrupts the frame data within four bytes, and the bench compares every streamed byte against the buffer contents.

// File: rtl/txr_pkg.sv
package txr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_STAT,
      ST_RD_BASE,
      ST_SEND,
      ST_WR_MISC,
      ST_WR_STAT
   } txr_state_e;

   // descriptor layout (byte offsets inside a 16-byte entry)
   localparam int unsigned OFS_BUFPTR = 0;
   localparam int unsigned OFS_LENSTAT = 4;
   localparam int unsigned OFS_MISC = 8;

   // status halfword bit positions
   localparam int unsigned SB_OWNED = 15;
   localparam int unsigned SB_FAULT = 14;
   localparam int unsigned SB_FIRST = 9;
   localparam int unsigned SB_FINAL = 8;

   localparam logic [31:0] MISC_CLEAN = 32'h0000_0000;
   localparam logic [31:0] MISC_FAULT = 32'h4000_0000;

   // the length field holds the negated byte count; only 12 bits are kept
   function automatic logic [11:0] count_from_field(input logic [15:0] enc);
      logic [15:0] neg;
      neg = 16'd0 - enc;
      return neg[11:0];
   endfunction

endpackage

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
   parameter int unsigned POLL_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (POLL_CYCLES == 0) begin : g_no_poll
         assign tick = 1'b0;
      end else begin : g_poll
         localparam int unsigned TW = $clog2(POLL_CYCLES + 1);
         localparam logic [TW-1:0] RELOAD = TW'(POLL_CYCLES - 1);
         logic [TW-1:0] left_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               left_q <= RELOAD;
            end else if (left_q == '0) begin
               left_q <= RELOAD;
            end else begin
               left_q <= left_q - 1'b1;
            end
         end
         assign tick = (left_q == '0);
      end
   endgenerate
endmodule

// File: rtl/txr_ring_index.sv
module txr_ring_index #(
   parameter int unsigned AW       = 16,
   parameter int unsigned MAX_LOG2 = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ring_base,
   input  logic [3:0]    size_log2,
   input  logic          advance,
   output logic [AW-1:0] desc_addr
);
   localparam int unsigned IW = MAX_LOG2;
   localparam int unsigned PADW = AW - IW - 4;

   logic [IW-1:0] idx_q;
   logic [IW-1:0] wrap_mask;
   logic [3:0]    eff_log2;
   logic [IW+3:0] entry_ofs;

   assign eff_log2 = (32'(size_log2) > MAX_LOG2) ? 4'(MAX_LOG2) : size_log2;

   genvar gi;
   generate
      for (gi = 0; gi < IW; gi++) begin : g_mask
         assign wrap_mask[gi] = (32'(eff_log2) > gi);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (advance) begin
         idx_q <= (idx_q + 1'b1) & wrap_mask;
      end
   end

   assign entry_ofs = {idx_q & wrap_mask, 4'h0};
   assign desc_addr = ring_base + {{PADW{1'b0}}, entry_ofs};
endmodule

// File: rtl/txr_byte_feeder.sv
module txr_byte_feeder #(
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic [11:0]   byte_count,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_ack,
   input  logic [31:0]   rd_data,
   output logic          out_valid,
   output logic [7:0]    out_data,
   output logic          out_last,
   input  logic          out_ready,
   output logic          done
);
   logic          active_q;
   logic          have_q;
   logic          done_q;
   logic [AW-1:0] ptr_q;
   logic [11:0]   remain_q;
   logic [31:0]   word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         have_q   <= 1'b0;
         done_q   <= 1'b0;
         ptr_q    <= '0;
         remain_q <= '0;
         word_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            active_q <= 1'b1;
            have_q   <= 1'b0;
            ptr_q    <= start_addr;
            remain_q <= byte_count;
         end else if (active_q) begin
            if (!have_q) begin
               if (rd_ack) begin
                  word_q <= rd_data;
                  have_q <= 1'b1;
               end
            end else if (out_ready) begin
               ptr_q    <= ptr_q + 1'b1;
               remain_q <= remain_q - 1'b1;
               if (ptr_q[1:0] == 2'b11) begin
                  have_q <= 1'b0;
               end
               if (remain_q == 12'd1) begin
                  active_q <= 1'b0;
                  have_q   <= 1'b0;
                  done_q   <= 1'b1;
               end
            end
         end
      end
   end

   always_comb begin
      unique case (ptr_q[1:0])
         2'd0: out_data = word_q[7:0];
         2'd1: out_data = word_q[15:8];
         2'd2: out_data = word_q[23:16];
         default: out_data = word_q[31:24];
      endcase
   end

   assign rd_req    = active_q && !have_q;
   assign rd_addr   = {ptr_q[AW-1:2], 2'b00};
   assign out_valid = active_q && have_q;
   assign out_last  = (remain_q == 12'd1);
   assign done      = done_q;
endmodule

// File: rtl/txr_ring_engine.sv
module txr_ring_engine #(
   parameter int unsigned AW          = 16,
   parameter int unsigned MAX_LOG2    = 6,
   parameter int unsigned MAX_BYTES   = 1536,
   parameter int unsigned POLL_CYCLES = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          poll_demand,
   input  logic [AW-1:0] ring_base,
   input  logic [15:0]   ring_len,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [3:0]    mem_be,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          mac_valid,
   output logic [7:0]    mac_data,
   output logic          mac_last,
   input  logic          mac_ready
);
   import txr_pkg::*;

   generate
      if (AW > 32 || AW < MAX_LOG2 + 5) begin : g_bad_aw
         $error("txr_ring_engine: AW must lie between MAX_LOG2+5 and 32");
      end
      if (MAX_LOG2 < 1 || MAX_LOG2 > 15) begin : g_bad_log2
         $error("txr_ring_engine: MAX_LOG2 must lie between 1 and 15");
      end
      if (MAX_BYTES < 1 || MAX_BYTES > 4095) begin : g_bad_max
         $error("txr_ring_engine: MAX_BYTES must lie between 1 and 4095");
      end
   endgenerate

   txr_state_e    state_q;
   logic [15:0]   stat_q;
   logic [15:0]   len_q;
   logic          fault_q;
   logic          pend_q;

   logic [AW-1:0] desc_addr;
   logic          advance;
   logic          poll_tick;
   logic          go;
   logic [11:0]   frame_cnt;
   logic          reject;
   logic [15:0]   stat_back;

   logic          fd_start;
   logic          fd_req;
   logic [AW-1:0] fd_addr;
   logic          fd_done;
   logic          fd_ack;

   logic [31:0]   unused_rdata;
   logic [11:0]   unused_len;
   assign unused_rdata = mem_rdata;
   assign unused_len   = ring_len[11:0];

   txr_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (poll_tick)
   );

   txr_ring_index #(.AW(AW), .MAX_LOG2(MAX_LOG2)) u_index (
      .clk       (clk),
      .rst_n     (rst_n),
      .ring_base (ring_base),
      .size_log2 (ring_len[15:12]),
      .advance   (advance),
      .desc_addr (desc_addr)
   );

   txr_byte_feeder #(.AW(AW)) u_feeder (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (fd_start),
      .start_addr (mem_rdata[AW-1:0]),
      .byte_count (frame_cnt),
      .rd_req     (fd_req),
      .rd_addr    (fd_addr),
      .rd_ack     (fd_ack),
      .rd_data    (mem_rdata),
      .out_valid  (mac_valid),
      .out_data   (mac_data),
      .out_last   (mac_last),
      .out_ready  (mac_ready),
      .done       (fd_done)
   );

   assign frame_cnt = count_from_field(len_q);
   assign reject    = !stat_q[SB_FIRST] || !stat_q[SB_FINAL] ||
                      (frame_cnt == 12'd0) || (32'(frame_cnt) > MAX_BYTES);
   assign stat_back = {1'b0, stat_q[SB_FAULT] | fault_q, stat_q[13:0]};
   assign go        = poll_demand || pend_q || poll_tick;
   assign fd_start  = (state_q == ST_RD_BASE) && mem_ack && !reject;
   assign fd_ack    = (state_q == ST_SEND) && mem_ack;
   assign advance   = (state_q == ST_WR_STAT) && mem_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         stat_q  <= '0;
         len_q   <= '0;
         fault_q <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         if (state_q == ST_IDLE) begin
            pend_q <= 1'b0;
         end else if (poll_demand) begin
            pend_q <= 1'b1;
         end
         unique case (state_q)
            ST_IDLE: begin
               if (go) state_q <= ST_RD_STAT;
            end
            ST_RD_STAT: begin
               if (mem_ack) begin
                  stat_q  <= mem_rdata[31:16];
                  len_q   <= mem_rdata[15:0];
                  state_q <= mem_rdata[16 + SB_OWNED] ? ST_RD_BASE : ST_IDLE;
               end
            end
            ST_RD_BASE: begin
               if (mem_ack) begin
                  fault_q <= reject;
                  state_q <= reject ? ST_WR_MISC : ST_SEND;
               end
            end
            ST_SEND: begin
               if (fd_done) state_q <= ST_WR_MISC;
            end
            ST_WR_MISC: begin
               if (mem_ack) state_q <= ST_WR_STAT;
            end
            ST_WR_STAT: begin
               if (mem_ack) state_q <= ST_RD_STAT;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_be    = 4'h0;
      mem_wdata = '0;
      unique case (state_q)
         ST_RD_STAT: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + AW'(OFS_LENSTAT);
         end
         ST_RD_BASE: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + AW'(OFS_BUFPTR);
         end
         ST_SEND: begin
            mem_req  = fd_req;
            mem_addr = fd_addr;
         end
         ST_WR_MISC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = desc_addr + AW'(OFS_MISC);
            mem_be    = 4'hF;
            mem_wdata = fault_q ? MISC_FAULT : MISC_CLEAN;
         end
         ST_WR_STAT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = desc_addr + AW'(OFS_LENSTAT);
            mem_be    = 4'b1100;
            mem_wdata = {stat_back, 16'h0000};
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/txr_ring_engine_chk.sv
module txr_ring_engine_chk #(
   parameter int unsigned AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [3:0]    mem_be,
   input logic [31:0]   mem_wdata,
   input logic          mem_ack,
   input logic          mac_valid,
   input logic [7:0]    mac_data,
   input logic          mac_last,
   input logic          mac_ready
);
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10

   AST_MAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mac_valid && !mac_ready |=> mac_valid && $stable(mac_data) && $stable(mac_last)); // R10

   AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00); // R3

   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      mac_valid && mac_ready && mac_last |=> !mac_valid); // R3

   AST_STAT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_be != 4'hF |-> mem_be == 4'b1100 && !mem_wdata[31]); // R4

   AST_MISC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_be == 4'hF |-> mem_wdata == 32'h0 || mem_wdata == 32'h4000_0000); // R5

   AST_NO_SEND_IN_WB: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !mac_valid); // R4
endmodule

bind txr_ring_engine txr_ring_engine_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_be    (mem_be),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .mac_valid (mac_valid),
   .mac_data  (mac_data),
   .mac_last  (mac_last),
   .mac_ready (mac_ready)
);

// File: tb/txr_ring_engine_bench.sv
`timescale 1ns/1ps
module txr_ring_engine_bench;
   localparam int AW = 16;
   localparam int POLL = 300;
   localparam logic [15:0] RBASE = 16'h0100;
   localparam logic [15:0] BUFB = 16'h0200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic poll_demand = 1'b0;
   logic [AW-1:0] ring_base = RBASE;
   logic [15:0] ring_len = 16'h2000;
   logic mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [3:0] mem_be;
   logic [31:0] mem_wdata, mem_rdata;
   logic mac_valid, mac_last, mac_ready;
   logic [7:0] mac_data;

   always #2.5 clk = ~clk;

   txr_ring_engine #(.AW(AW), .MAX_LOG2(6), .MAX_BYTES(1536), .POLL_CYCLES(POLL)) u_txr_ring_engine (
      .clk(clk), .rst_n(rst_n), .poll_demand(poll_demand), .ring_base(ring_base), .ring_len(ring_len),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .mac_valid(mac_valid), .mac_data(mac_data), .mac_last(mac_last), .mac_ready(mac_ready));

   // memory model with host write path
   logic [31:0] mem [0:255];
   logic hw_en = 1'b0;
   logic [15:0] hw_addr = '0;
   logic [31:0] hw_data = '0;
   logic ack_r = 1'b0;
   logic [31:0] rdat_r = '0;
   assign mem_ack = ack_r;
   assign mem_rdata = rdat_r;

   always @(posedge clk) begin
      if (hw_en) mem[hw_addr[9:2]] <= hw_data;
      if (!rst_n) begin
         ack_r <= 1'b0;
      end else if (mem_req && !ack_r) begin
         ack_r <= 1'b1;
         rdat_r <= mem[mem_addr[9:2]];
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
         end
      end else begin
         ack_r <= 1'b0;
      end
   end

   // MAC sink
   logic rmode = 1'b0;
   int rcnt = 0;
   always @(negedge clk) begin
      rcnt <= rcnt + 1;
      mac_ready <= rmode ? (rcnt % 3 != 0) : 1'b1;
   end
   initial mac_ready = 1'b1;

   logic [7:0] cap [0:255];
   int cap_n = 0;
   int last_n = 0;
   int last_pos = -1;
   int hold_viol = 0;
   logic cap_clr = 1'b0;
   logic pv_valid = 1'b0, pv_ready = 1'b0, pv_last = 1'b0;
   logic [7:0] pv_data = '0;
   always @(posedge clk) begin
      if (cap_clr) begin
         cap_n <= 0; last_n <= 0; last_pos <= -1;
      end else if (mac_valid && mac_ready) begin
         if (cap_n < 256) cap[cap_n[7:0]] <= mac_data;
         cap_n <= cap_n + 1;
         if (mac_last) begin last_n <= last_n + 1; last_pos <= cap_n; end
      end
      if (rst_n && pv_valid && !pv_ready &&
          (!mac_valid || mac_data != pv_data || mac_last != pv_last))
         hold_viol <= hold_viol + 1;
      pv_valid <= mac_valid; pv_ready <= mac_ready; pv_data <= mac_data; pv_last <= mac_last;
   end

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [7:0] pat(input int a);
      logic [7:0] v;
      v = 8'(a * 3) ^ 8'hA5;
      return v;
   endfunction

   task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic hwrite(input logic [15:0] a, input logic [31:0] d);
      hw_en = 1'b1; hw_addr = a; hw_data = d;
      @(negedge clk);
      hw_en = 1'b0;
   endtask

   task automatic clear_cap();
      cap_clr = 1'b1;
      @(negedge clk);
      cap_clr = 1'b0;
   endtask

   task automatic kick();
      poll_demand = 1'b1;
      @(negedge clk);
      poll_demand = 1'b0;
   endtask

   function automatic logic [15:0] dptr(input int idx);
      return RBASE + 16'(16 * idx);
   endfunction

   task automatic post(input int idx, input logic [15:0] bufa, input logic [15:0] lenenc, input logic [15:0] st);
      hwrite(dptr(idx), {16'h0, bufa});
      hwrite(dptr(idx) + 16'd8, 32'hFFFF_FFFF);
      hwrite(dptr(idx) + 16'd4, {st, lenenc});
   endtask

   task automatic wait_done(input int idx, input int limit, output logic ok);
      ok = 1'b0;
      for (int t = 0; t < limit; t++) begin
         @(negedge clk);
         if (!mem[(dptr(idx) + 16'd4) >> 2][31]) begin ok = 1'b1; break; end
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic check_frame(input string req, input int n, input int bufa);
      int bad;
      bad = 0;
      chk(cap_n == n, req, "byte count", cap_n, n);
      for (int k = 0; k < n && k < 256; k++)
         if (cap[k] != pat(bufa + k)) bad++;
      chk(bad == 0, req, "byte mismatches", bad, 0);
      if (n > 0) chk(last_n == 1 && last_pos == n - 1, req, "last marker position", last_pos, n - 1);
      else chk(last_n == 0, req, "last markers", last_n, 0);
   endtask

   task automatic check_wb(input string req, input int idx, input logic [15:0] st, input logic err);
      logic [15:0] exp_st;
      logic [31:0] exp_misc;
      exp_st = (st & 16'h7FFF) | (err ? 16'h4000 : 16'h0);
      exp_misc = err ? 32'h4000_0000 : 32'h0;
      chk(mem[(dptr(idx) + 16'd4) >> 2][31:16] == exp_st, req, "status writeback",
          int'(mem[(dptr(idx) + 16'd4) >> 2][31:16]), int'(exp_st));
      chk(mem[(dptr(idx) + 16'd8) >> 2] == exp_misc, req, "misc writeback",
          int'(mem[(dptr(idx) + 16'd8) >> 2]), int'(exp_misc));
   endtask

   typedef struct packed {
      logic [15:0] lenenc;
      logic [15:0] st;
      logic [7:0]  bofs;
      logic        rm;
      logic        err;
   } vec_t;

   localparam vec_t VEC [0:6] = '{
      '{16'hFFFF, 16'h8300, 8'd0,  1'b0, 1'b0},   // 1 byte, aligned
      '{16'hFFFB, 16'h8300, 8'd1,  1'b0, 1'b0},   // 5 bytes, offset 1
      '{16'hFFC0, 16'h8300, 8'd3,  1'b1, 1'b0},   // 64 bytes, offset 3, ready gaps
      '{16'hFFFC, 16'h8200, 8'd0,  1'b0, 1'b1},   // end-of-frame flag missing
      '{16'hF000, 16'h8300, 8'd0,  1'b0, 1'b1},   // zero count
      '{16'hF830, 16'h8300, 8'd0,  1'b0, 1'b1},   // count above limit
      '{16'hFFE9, 16'h8300, 8'd2,  1'b1, 1'b0}    // 23 bytes, offset 2
   };

   int cur = 0;
   logic ok;

   initial begin
      @(negedge clk);
      for (int w = 0; w < 128; w++)
         hwrite(BUFB + 16'(4 * w), {pat(BUFB + 4*w + 3), pat(BUFB + 4*w + 2), pat(BUFB + 4*w + 1), pat(BUFB + 4*w)});
      for (int w = 0; w < 64; w++) hwrite(RBASE + 16'(4 * w), 32'h0);
      // R1: reset state
      chk(!mem_req && !mac_valid, "R1", "outputs idle in reset", {mem_req, mac_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: demand from idle reads status of entry 0 on the next cycle (R1: entry 0 at ring_base)
      kick();
      chk(mem_req && !mem_we && mem_addr == RBASE + 16'd4, "R8", "status read after demand", int'(mem_addr), int'(RBASE + 16'd4));
      repeat (10) @(negedge clk);

      // table walk: R3, R4, R5, R6 (4-entry ring wraps)
      for (int v = 0; v < 7; v++) begin
         int n;
         rmode = VEC[v].rm;
         clear_cap();
         post(cur, BUFB + 16'(VEC[v].bofs), VEC[v].lenenc, VEC[v].st);
         kick();
         wait_done(cur, 3000, ok);
         chk(ok, "R6", "entry at expected index returned", int'(ok), 1);
         n = VEC[v].err ? 0 : int'(16'(16'd0 - VEC[v].lenenc) & 16'h0FFF);
         check_frame(VEC[v].err ? "R5" : "R3", n, int'(BUFB) + int'(VEC[v].bofs));
         check_wb(VEC[v].err ? "R5" : "R4", cur, VEC[v].st, VEC[v].err);
         cur = (cur + 1) % 4;
      end
      rmode = 1'b0;

      // R2: host-held entry is left untouched, index does not move
      clear_cap();
      hwrite(dptr(cur), {16'h0, BUFB});
      hwrite(dptr(cur) + 16'd8, 32'h1234_5678);
      hwrite(dptr(cur) + 16'd4, 32'h0300_FFF8);
      kick();
      repeat (40) @(negedge clk);
      chk(cap_n == 0, "R2", "bytes for host-held entry", cap_n, 0);
      chk(mem[(dptr(cur) + 16'd4) >> 2] == 32'h0300_FFF8, "R2", "status untouched",
          int'(mem[(dptr(cur) + 16'd4) >> 2]), 32'h0300_FFF8);
      chk(mem[(dptr(cur) + 16'd8) >> 2] == 32'h1234_5678, "R2", "misc untouched",
          int'(mem[(dptr(cur) + 16'd8) >> 2]), 32'h1234_5678);
      post(cur, BUFB, 16'hFFF8, 16'h8300);
      kick();
      wait_done(cur, 3000, ok);
      chk(ok, "R2", "same index served once owned", int'(ok), 1);
      check_frame("R2", 8, int'(BUFB));
      cur = (cur + 1) % 4;

      // R7: two owned entries, one demand
      clear_cap();
      post(cur, BUFB + 16'd4, 16'hFFF6, 16'h8300);
      post((cur + 1) % 4, BUFB + 16'd20, 16'hFFFD, 16'h8300);
      kick();
      wait_done((cur + 1) % 4, 3000, ok);
      chk(ok, "R7", "second entry sent on one demand", int'(ok), 1);
      chk(cap_n == 13, "R7", "total chained bytes", cap_n, 13);
      check_wb("R7", cur, 16'h8300, 1'b0);
      cur = (cur + 2) % 4;

      // R9: periodic poll, no demand
      clear_cap();
      post(cur, BUFB, 16'hFFFE, 16'h8300);
      wait_done(cur, POLL + 60, ok);
      chk(ok, "R9", "picked up by periodic poll", int'(ok), 1);
      check_frame("R9", 2, int'(BUFB));
      cur = (cur + 1) % 4;

      // R6: ring size field 0 keeps engine on entry 0
      ring_len = 16'h0000;
      for (int r = 0; r < 2; r++) begin
         clear_cap();
         post(0, BUFB + 16'(r), 16'hFFFD, 16'h8300);
         kick();
         wait_done(0, 3000, ok);
         chk(ok, "R6", "single-entry ring reuses entry 0", int'(ok), 1);
         check_frame("R6", 3, int'(BUFB) + r);
      end

      // R10: MAC byte held while not accepted
      chk(hold_viol == 0, "R10", "held byte changed while not ready", hold_viol, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule